// File: doc/BRIEF.md
# Polled Character Port

This block is a bus slave that lets a processor move single characters to and from a slow device by polling. A character source (for example a keyboard front end) presents an 8-bit code with a one-cycle strobe. The block latches the code and raises a receive-ready flag. Software watches that flag in a status register, then reads the data register. The read itself clears the flag, so the next poll waits for a fresh character.

On the transmit side a transmit-ready flag shows that the display can accept a code. A bus write to the transmit data register loads the character and clears that flag. The block then offers the character to the display with a valid strobe, which stays up until the display acknowledges it. After the acknowledge the flag returns, and software may send the next code.

Four byte-wide registers sit at word offsets 0 to 3 of the slave's address space. Bus reads return data one cycle after the request.

Top module: `chario_port`

## Requirements
- R1: After reset, receive-ready and overrun are 0, transmit-ready is 1, `out_valid` is 0 and `bus_rdata` is 0.
- R2: An `in_valid` pulse stores `in_char` in the receive buffer and sets receive-ready, which is bit 3 of the receive status register at offset 1.
- R3: A bus read of the receive data register at offset 0 returns the buffered character and clears receive-ready (and overrun) in the same cycle.
- R4: A character that arrives while receive-ready is still 1 replaces the buffered one and sets a sticky overrun bit, which is bit 4 of the receive status. Overrun holds until the next read of offset 0. An arrival in the same cycle as that read loads the new character and leaves receive-ready at 1 without overrun.
- R5: Reading either status register changes no state. Every status bit other than bits 3 and 4 (receive) or bit 3 (transmit) reads 0.
- R6: A bus write to the transmit data register at offset 2 while transmit-ready is 1 loads `out_char` from the low byte of `bus_wdata`. In the next cycle `out_valid` is 1 and transmit-ready, bit 3 of the transmit status at offset 3, is 0.
- R7: `out_valid` and `out_char` hold steady until `out_ack` is sampled high. At that same clock edge `out_valid` drops and transmit-ready returns to 1. Exactly one of `out_valid` and transmit-ready is 1 at any time.
- R8: A write to offset 2 while transmit-ready is 0 is ignored: the pending character and `out_valid` are unchanged.
- R9: `bus_rvalid` is 1 exactly in the cycle after a read request, with `bus_rdata` valid in that cycle. Writes to offsets 0, 1 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register word offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| in_valid | input | 1 | Character arrival strobe from the source |
| in_char | input | 8 | Arriving character code |
| out_valid | output | 1 | Character offered to the display |
| out_char | output | 8 | Offered character code |
| out_ack | input | 1 | Display has taken the character |

## Verification
Every register here sits one edge from its cause. Flag and buffer changes from a device strobe or a bus access, read data with `bus_rvalid`, and the transmit strobe after a write or an acknowledge all appear after the edge that samples the stimulus. The bench drives every input on the falling edge. It then waits exactly one further falling edge, so one rising edge has passed, before it samples a result. A result that comes a cycle early or late is therefore read at the wrong point and flagged. Side-effect checks read the status back through the bus right after the access under test, before any other stimulus.

// File: rtl/chario_pkg.sv
package chario_pkg;
  localparam int unsigned REG_ADDR_W = 2;
  localparam int unsigned READY_BIT  = 3;
  localparam int unsigned OVR_BIT    = 4;

  typedef enum logic [REG_ADDR_W-1:0] {
    RG_RX_DATA = 2'd0,
    RG_RX_STAT = 2'd1,
    RG_TX_DATA = 2'd2,
    RG_TX_STAT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic rd_any;
    logic rd_rx_data;
    logic wr_tx_data;
  } strobe_t;
endpackage

// File: rtl/chario_decode.sv
module chario_decode
  import chario_pkg::*;
(
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  output strobe_t               stb
);
  always_comb begin
    stb.rd_any     = bus_sel && !bus_wr;
    stb.rd_rx_data = bus_sel && !bus_wr && (bus_addr == RG_RX_DATA);
    stb.wr_tx_data = bus_sel &&  bus_wr && (bus_addr == RG_TX_DATA);
  end
endmodule

// File: rtl/chario_rx_side.sv
module chario_rx_side #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_char,
  input  logic              rd_data_stb,
  output logic [DATA_W-1:0] rx_char,
  output logic              rx_ready,
  output logic              rx_overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_char    <= '0;
      rx_ready   <= 1'b0;
      rx_overrun <= 1'b0;
    end else if (in_valid) begin
      rx_char  <= in_char;
      rx_ready <= 1'b1;
      if (rd_data_stb)   rx_overrun <= 1'b0;
      else if (rx_ready) rx_overrun <= 1'b1;
    end else if (rd_data_stb) begin
      rx_ready   <= 1'b0;
      rx_overrun <= 1'b0;
    end
  end

  // R2: arrival latches the code and raises ready
  a_r2_arrival_sets: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> rx_ready && (rx_char == $past(in_char)));
  // R3: a data read with no arrival empties the buffer
  a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_data_stb && !in_valid) |=> !rx_ready && !rx_overrun);
  // R4: arrival onto a full buffer flags overrun
  a_r4_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rx_ready && !rd_data_stb) |=> rx_overrun);
  // R4: overrun is sticky until a data read
  a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && !rd_data_stb) |=> rx_overrun);
endmodule

// File: rtl/chario_tx_side.sv
module chario_tx_side #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data_stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              out_ack,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_char,
  output logic              tx_ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_char  <= '0;
      tx_ready  <= 1'b1;
    end else if (wr_data_stb && tx_ready) begin
      out_char  <= wdata;
      out_valid <= 1'b1;
      tx_ready  <= 1'b0;
    end else if (out_valid && out_ack) begin
      out_valid <= 1'b0;
      tx_ready  <= 1'b1;
    end
  end

  // R6: an accepted write offers the character next cycle
  a_r6_load: assert property (@(posedge clk) disable iff (rst)
    (wr_data_stb && tx_ready) |=> out_valid && !tx_ready && (out_char == $past(wdata)));
  // R7: offer held until acknowledged
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ack) |=> out_valid && $stable(out_char));
  // R7: acknowledge releases the strobe and restores ready
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ack) |=> !out_valid && tx_ready);
  // R7: exactly one of strobe and ready
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({out_valid, tx_ready}) == 1);
  // R8: writes while busy are dropped
  a_r8_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_data_stb && !tx_ready) |=> $stable(out_char));
endmodule

// File: rtl/chario_readback.sv
module chario_readback
  import chario_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_stb,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     rx_char,
  input  logic                  rx_ready,
  input  logic                  rx_overrun,
  input  logic [DATA_W-1:0]     tx_char,
  input  logic                  tx_ready,
  output logic [DATA_W-1:0]     rdata,
  output logic                  rvalid
);
  logic [DATA_W-1:0] rx_stat_w, tx_stat_w, mux_w;

  always_comb begin
    rx_stat_w            = '0;
    rx_stat_w[READY_BIT] = rx_ready;
    rx_stat_w[OVR_BIT]   = rx_overrun;
    tx_stat_w            = '0;
    tx_stat_w[READY_BIT] = tx_ready;
    unique case (reg_sel_e'(addr))
      RG_RX_DATA: mux_w = rx_char;
      RG_RX_STAT: mux_w = rx_stat_w;
      RG_TX_DATA: mux_w = tx_char;
      RG_TX_STAT: mux_w = tx_stat_w;
      default:    mux_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_stb;
      if (rd_stb) rdata <= mux_w;
    end
  end

  // R9: response strobe follows each read by one cycle
  a_r9_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rvalid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> !rvalid);
endmodule

// File: rtl/chario_port.sv
module chario_port
  import chario_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  bus_rvalid,
  input  logic                  in_valid,
  input  logic [DATA_W-1:0]     in_char,
  output logic                  out_valid,
  output logic [DATA_W-1:0]     out_char,
  input  logic                  out_ack
);
  strobe_t           stb;
  logic [DATA_W-1:0] rx_char;
  logic              rx_ready, rx_overrun, tx_ready;

  chario_decode i_decode (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .stb     (stb)
  );

  chario_rx_side #(.DATA_W(DATA_W)) i_rx (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_char    (in_char),
    .rd_data_stb(stb.rd_rx_data),
    .rx_char    (rx_char),
    .rx_ready   (rx_ready),
    .rx_overrun (rx_overrun)
  );

  chario_tx_side #(.DATA_W(DATA_W)) i_tx (
    .clk        (clk),
    .rst        (rst),
    .wr_data_stb(stb.wr_tx_data),
    .wdata      (bus_wdata),
    .out_ack    (out_ack),
    .out_valid  (out_valid),
    .out_char   (out_char),
    .tx_ready   (tx_ready)
  );

  chario_readback #(.DATA_W(DATA_W)) i_rb (
    .clk       (clk),
    .rst       (rst),
    .rd_stb    (stb.rd_any),
    .addr      (bus_addr),
    .rx_char   (rx_char),
    .rx_ready  (rx_ready),
    .rx_overrun(rx_overrun),
    .tx_char   (out_char),
    .tx_ready  (tx_ready),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid)
  );

  // R1: flags come out of reset in their idle state
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> !rx_ready && tx_ready && !out_valid);
endmodule

// File: tb/test_chario_port.sv
`timescale 1ns/100ps
module test_chario_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       bus_rvalid;
  logic       in_valid = 1'b0;
  logic [7:0] in_char = '0;
  logic       out_valid, out_ack = 1'b0;
  logic [7:0] out_char;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  chario_port i_chario_port (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .in_valid(in_valid), .in_char(in_char),
    .out_valid(out_valid), .out_char(out_char), .out_ack(out_ack)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // drive at falling edge, sample one full cycle later
  task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic v);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic push_char(input logic [7:0] c);
    in_valid = 1'b1; in_char = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic v;
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 out_valid", out_valid, 0);
    bus_read(2'd1, d, v);
    check("R1 rx status", d, 8'h00);
    bus_read(2'd3, d, v);
    check("R1 tx status", d, 8'h08);
  endtask

  task automatic t_receive();
    logic [7:0] d; logic v;
    push_char(8'h41);
    bus_read(2'd1, d, v);
    check("R2 ready set", d, 8'h08);
    bus_read(2'd1, d, v);
    check("R5 status read no side effect", d, 8'h08);
    bus_read(2'd0, d, v);
    check("R3 data", d, 8'h41);
    check("R9 rvalid", v, 1);
    check("R9 rvalid one cycle", bus_rvalid, 1);
    @(negedge clk);
    check("R9 rvalid drops", bus_rvalid, 0);
    bus_read(2'd1, d, v);
    check("R3 ready cleared", d, 8'h00);
  endtask

  task automatic t_overrun();
    logic [7:0] d; logic v;
    push_char(8'h31);
    push_char(8'h32);
    bus_read(2'd1, d, v);
    check("R4 overrun set", d, 8'h18);
    bus_read(2'd1, d, v);
    check("R4 overrun sticky", d, 8'h18);
    bus_read(2'd0, d, v);
    check("R4 newest kept", d, 8'h32);
    bus_read(2'd1, d, v);
    check("R4 overrun cleared", d, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d; logic v;
    push_char(8'h55);
    in_valid = 1'b1; in_char = 8'h66;
    bus_read(2'd0, d, v);
    in_valid = 1'b0;
    check("R4 collide returns old", d, 8'h55);
    bus_read(2'd1, d, v);
    check("R4 collide ready no overrun", d, 8'h08);
    bus_read(2'd0, d, v);
    check("R4 collide new char", d, 8'h66);
  endtask

  task automatic t_transmit();
    logic [7:0] d; logic v;
    bus_write(2'd2, 8'h48);
    check("R6 out_valid", out_valid, 1);
    check("R6 out_char", out_char, 8'h48);
    bus_read(2'd3, d, v);
    check("R6 tx ready cleared", d, 8'h00);
    bus_write(2'd2, 8'h99);
    repeat (3) @(negedge clk);
    check("R8 char kept", out_char, 8'h48);
    check("R7 held without ack", out_valid, 1);
    out_ack = 1'b1;
    @(negedge clk);
    out_ack = 1'b0;
    check("R7 valid released", out_valid, 0);
    bus_read(2'd3, d, v);
    check("R7 tx ready back", d, 8'h08);
    check("R8 no second offer", out_valid, 0);
  endtask

  task automatic t_ignored_writes();
    logic [7:0] d; logic v;
    bus_write(2'd0, 8'hFF);
    bus_write(2'd1, 8'hFF);
    bus_write(2'd3, 8'h00);
    check("R9 no offer", out_valid, 0);
    bus_read(2'd1, d, v);
    check("R9 rx status untouched", d, 8'h00);
    bus_read(2'd3, d, v);
    check("R9 tx status untouched", d, 8'h08);
    bus_read(2'd0, d, v);
    check("R9 rx buffer untouched", d, 8'h66);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_receive();
    t_overrun();
    t_collide();
    t_transmit();
    t_ignored_writes();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule